// File: doc/BRIEF.md
# Doubleword Shift Execution Unit

This block is the 64-bit shift datapath of an integer execution stage. It takes one 64-bit operand and shifts it left logically, right logically or right arithmetically. The shift count comes from one of three sources: a 5-bit immediate field, that immediate plus 32, or the low six bits of a second 64-bit register value. The decoder supplies a small 4-bit operation code that selects both the direction and the count source.

All three count sources feed a single six-stage logarithmic right shifter. For left shifts, the operand is bit-reversed before the shifter and the result is bit-reversed after it. The 64-bit result is captured in one output register, so it appears one clock after the inputs are presented. An operation code outside the nine legal values gives a zero result.

Top module: `dshift_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o` is zero. With reset released, `result_o` shows the result for the inputs sampled at the previous rising clock edge.
- R2: Left logical shifts (codes 1, 4, 7) fill the vacated low-order bits with zeros.
- R3: Right logical shifts (codes 2, 5, 8) fill the vacated high-order bits with zeros.
- R4: Right arithmetic shifts (codes 3, 6, 9) fill the vacated high-order bits with copies of bit 63 of the operand.
- R5: Register-count forms (codes 7, 8, 9) shift by `shamt_reg_i[5:0]`, giving 0 to 63. Bits 63:6 of `shamt_reg_i` have no effect on the result. No other form reads `shamt_reg_i` at all.
- R6: Immediate forms (codes 1, 2, 3) shift by `imm_i`, giving 0 to 31.
- R7: Plus-32 forms (codes 4, 5, 6) shift by 32 + `imm_i`, giving 32 to 63.
- R8: The codes 0 and 10 to 15 produce a zero result.
- R9: A shift count of zero passes the operand through unchanged in every form.
- R10: An arithmetic right shift by 63 gives all ones for an operand with bit 63 set, and all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (1..9 legal) |
| operand_i | input | 64 | Value to be shifted |
| imm_i | input | 5 | Immediate shift count |
| shamt_reg_i | input | 64 | Register supplying the count for the register forms |
| result_o | output | 64 | Registered shift result |

## Verification
The block has no state apart from the output register, so a fault in any part of it shows at `result_o` on the very next clock. A fault in the count selection or in one barrel stage corrupts only the results whose count uses that stage bit or that count source. The stimulus therefore covers every count from 0 to 63 in every form, and uses operands with both signs. A wrong fill value shows in the top or bottom bits right after a nonzero shift. A decode fault shows as a nonzero result for an illegal code, or as the wrong direction for a legal one.

// File: rtl/dshift_pkg.sv
package dshift_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_SLL_I  = 4'd1,
        OP_SRL_I  = 4'd2,
        OP_SRA_I  = 4'd3,
        OP_SLL_H  = 4'd4,
        OP_SRL_H  = 4'd5,
        OP_SRA_H  = 4'd6,
        OP_SLL_R  = 4'd7,
        OP_SRL_R  = 4'd8,
        OP_SRA_R  = 4'd9
    } shift_op_e;

    typedef enum logic [1:0] {
        SRC_IMM  = 2'd0,
        SRC_HIGH = 2'd1,
        SRC_REG  = 2'd2
    } amt_src_e;

    typedef struct packed {
        logic     legal;
        logic     left;
        logic     arith;
        amt_src_e src;
    } shift_ctrl_t;

endpackage

// File: rtl/dshift_ctrl.sv
module dshift_ctrl
    import dshift_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic [3:0]       op_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [AMT_W-1:0] reg_amt_i,
    output shift_ctrl_t      ctrl_o,
    output logic [AMT_W-1:0] amt_o
);
    localparam int HALF = DATA_W / 2;

    always_comb begin
        ctrl_o = '{legal: 1'b1, left: 1'b0, arith: 1'b0, src: SRC_IMM};
        unique case (op_i)
            OP_SLL_I: ctrl_o = '{1'b1, 1'b1, 1'b0, SRC_IMM};
            OP_SRL_I: ctrl_o = '{1'b1, 1'b0, 1'b0, SRC_IMM};
            OP_SRA_I: ctrl_o = '{1'b1, 1'b0, 1'b1, SRC_IMM};
            OP_SLL_H: ctrl_o = '{1'b1, 1'b1, 1'b0, SRC_HIGH};
            OP_SRL_H: ctrl_o = '{1'b1, 1'b0, 1'b0, SRC_HIGH};
            OP_SRA_H: ctrl_o = '{1'b1, 1'b0, 1'b1, SRC_HIGH};
            OP_SLL_R: ctrl_o = '{1'b1, 1'b1, 1'b0, SRC_REG};
            OP_SRL_R: ctrl_o = '{1'b1, 1'b0, 1'b0, SRC_REG};
            OP_SRA_R: ctrl_o = '{1'b1, 1'b0, 1'b1, SRC_REG};
            default:  ctrl_o = '{1'b0, 1'b0, 1'b0, SRC_IMM};
        endcase
    end

    always_comb begin
        case (ctrl_o.src)
            SRC_HIGH: amt_o = AMT_W'(HALF) + AMT_W'(imm_i);
            SRC_REG:  amt_o = reg_amt_i;
            default:  amt_o = AMT_W'(imm_i);
        endcase
    end

endmodule

// File: rtl/dshift_rev.sv
module dshift_rev #(
    parameter int W = 64
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign out_o[i] = in_i[W-1-i];
    end
endmodule

// File: rtl/dshift_barrel.sv
module dshift_barrel #(
    parameter int W = 64,
    localparam int STAGES = $clog2(W)
) (
    input  logic [W-1:0]      data_i,
    input  logic [STAGES-1:0] amt_i,
    input  logic              fill_i,
    output logic [W-1:0]      data_o
);
    logic [W-1:0] stage [STAGES+1];

    assign stage[0] = data_i;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt_i[k]
            ? {{STEP{fill_i}}, stage[k][W-1:STEP]}
            : stage[k];
    end

    assign data_o = stage[STAGES];
endmodule

// File: rtl/dshift_unit.sv
module dshift_unit
    import dshift_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5,
    localparam int AMT_W = $clog2(DATA_W)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] shamt_reg_i,
    output logic [DATA_W-1:0] result_o
);
    typedef struct packed {
        logic [DATA_W-1:0] result;
    } state_t;

    state_t            st_d, st_q;
    shift_ctrl_t       ctrl;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] operand_rev, shift_in, shift_out, shift_out_rev;
    logic              fill;

    dshift_ctrl #(.DATA_W(DATA_W), .IMM_W(IMM_W)) ctrl_i (
        .op_i      (op_i),
        .imm_i     (imm_i),
        .reg_amt_i (shamt_reg_i[AMT_W-1:0]),
        .ctrl_o    (ctrl),
        .amt_o     (amt)
    );

    dshift_rev #(.W(DATA_W)) rev_in_i (
        .in_i  (operand_i),
        .out_o (operand_rev)
    );

    assign shift_in = ctrl.left ? operand_rev : operand_i;
    assign fill     = ctrl.arith & operand_i[DATA_W-1];

    dshift_barrel #(.W(DATA_W)) barrel_i (
        .data_i (shift_in),
        .amt_i  (amt),
        .fill_i (fill),
        .data_o (shift_out)
    );

    dshift_rev #(.W(DATA_W)) rev_out_i (
        .in_i  (shift_out),
        .out_o (shift_out_rev)
    );

    always_comb begin
        st_d = st_q;
        if (!ctrl.legal) begin
            st_d.result = '0;
        end else if (ctrl.left) begin
            st_d.result = shift_out_rev;
        end else begin
            st_d.result = shift_out;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;

endmodule

// File: rtl/dshift_unit_chk.sv
module dshift_unit_chk
    import dshift_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] operand_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [DATA_W-1:0] shamt_reg_i,
    input logic [DATA_W-1:0] result_o
);
    localparam int HALF = DATA_W / 2;
    localparam int AMT_W = $clog2(DATA_W);

    logic live_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) live_q <= 1'b0;
        else         live_q <= 1'b1;
    end

    // R1
    p_reset_zero_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (!rst_ni -> result_o == '0));

    // R2
    p_left_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && $past(op_i) == OP_SLL_H |-> result_o[HALF-1:0] == '0);

    // R3
    p_right_fill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && $past(op_i) == OP_SRL_H |-> result_o[DATA_W-1:HALF] == '0);

    // R4
    p_sign_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && $past(op_i) == OP_SRA_H
        |-> result_o[DATA_W-1:HALF-1] == {(HALF+1){$past(operand_i[DATA_W-1])}});

    // R8
    p_illegal_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && ($past(op_i) == 4'd0 || $past(op_i) > 4'd9) |-> result_o == '0);

    // R9
    p_zero_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && $past(op_i) == OP_SRL_R && $past(shamt_reg_i[AMT_W-1:0]) == '0
        |-> result_o == $past(operand_i));

    // R10
    p_sra_max_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        live_q && $past(op_i) == OP_SRA_R && $past(shamt_reg_i[AMT_W-1:0]) == '1
        |-> result_o == {DATA_W{$past(operand_i[DATA_W-1])}});

endmodule

bind dshift_unit dshift_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op_i),
    .operand_i   (operand_i),
    .imm_i       (imm_i),
    .shamt_reg_i (shamt_reg_i),
    .result_o    (result_o)
);

// File: tb/dshift_unit_tb.sv
module dshift_unit_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  op_i = '0;
    logic [63:0] operand_i = '0;
    logic [4:0]  imm_i = '0;
    logic [63:0] shamt_reg_i = '0;
    logic [63:0] result_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit mon_en   = 1'b0;
    bit done     = 1'b0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #10 clk_i = ~clk_i;

    dshift_unit dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_i        (op_i),
        .operand_i   (operand_i),
        .imm_i       (imm_i),
        .shamt_reg_i (shamt_reg_i),
        .result_o    (result_o)
    );

    function automatic logic [63:0] model(int op, logic [63:0] x, logic [4:0] imm,
                                          logic [63:0] r);
        int n;
        if (op < 1 || op > 9) return 64'd0;
        if (op <= 3)      n = int'(imm);
        else if (op <= 6) n = 32 + int'(imm);
        else              n = int'(r[5:0]);
        case (op % 3)
            1:       return x << n;
            2:       return x >> n;
            default: return 64'($signed(x) >>> n);
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: result %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(int op, logic [63:0] x, logic [4:0] imm, logic [63:0] r,
                         string tag);
        item_t it;
        @(negedge clk_i);
        op_i        = 4'(op);
        operand_i   = x;
        imm_i       = imm;
        shamt_reg_i = r;
        it.exp = model(op, x, imm, r);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk_i);
            #5;
            if (mon_en && sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(it.tag, result_o, it.exp);
            end
        end
    end

    initial begin : watchdog
        int cyc = 0;
        while (!done) begin
            @(posedge clk_i);
            cyc++;
            if (cyc > 20000) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog: run %0d cycles expected under %0d", cyc, 20000);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin : driver
        logic [63:0] neg = 64'hF0E1_D2C3_B4A5_9687;
        logic [63:0] pos = 64'h7123_4567_89AB_CDEF;
        // R1: reset state, also with inputs active
        op_i = 4'd1; operand_i = '1; imm_i = 5'd3;
        repeat (2) @(posedge clk_i);
        #5 check("R1", result_o, 64'd0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        mon_en = 1'b1;

        // R2 / R3 / R4 fills
        drive(1, '1, 5'd7, '0, "R2");
        drive(4, '1, 5'd0, '0, "R2");
        drive(7, neg, 5'd0, 64'd45, "R2");
        drive(2, '1, 5'd9, '0, "R3");
        drive(5, neg, 5'd3, '0, "R3");
        drive(8, neg, 5'd0, 64'd60, "R3");
        drive(3, neg, 5'd12, '0, "R4");
        drive(6, neg, 5'd1, '0, "R4");
        drive(9, pos, 5'd0, 64'd40, "R4");
        // R5: upper bits of shift register ignored; other forms ignore it entirely
        drive(8, neg, 5'd0, 64'hFFFF_FFFF_FFFF_FFC5, "R5");
        drive(7, pos, 5'd0, 64'hA5A5_0000_0000_0041, "R5");
        drive(2, neg, 5'd4, '1, "R5");
        // R6 / R7 range ends
        drive(2, neg, 5'd31, '0, "R6");
        drive(1, pos, 5'd31, '0, "R6");
        drive(5, neg, 5'd31, '0, "R7");
        drive(4, pos, 5'd0, '0, "R7");
        drive(6, neg, 5'd0, '0, "R7");
        // R8 illegal codes
        drive(0, neg, 5'd1, 64'd1, "R8");
        for (int c = 10; c < 16; c++) drive(c, '1, 5'd2, 64'd2, "R8");
        // R9 zero amount
        drive(1, neg, 5'd0, '1, "R9");
        drive(2, pos, 5'd0, '1, "R9");
        drive(3, neg, 5'd0, '1, "R9");
        drive(7, neg, 5'd0, 64'hFFC0, "R9");
        drive(8, pos, 5'd0, 64'h40, "R9");
        drive(9, neg, 5'd0, 64'hC0, "R9");
        // R10 arithmetic by 63
        drive(9, neg, 5'd0, 64'd63, "R10");
        drive(9, pos, 5'd0, 64'd63, "R10");
        drive(6, neg, 5'd31, '0, "R10");
        drive(6, pos, 5'd31, '0, "R10");
        // sweep of every count in every form (R5, R6, R7)
        for (int op = 1; op <= 9; op++) begin
            for (int s = 0; s < 64; s++) begin
                logic [63:0] x = {$urandom(), $urandom()};
                if (op >= 7)
                    drive(op, x, 5'($urandom()), {58'($urandom()), 6'(s)}, "R5");
                else if (s < 32)
                    drive(op, x, 5'(s), {$urandom(), $urandom()},
                          op <= 3 ? "R6" : "R7");
            end
        end
        // R1: reset clears a nonzero result
        drive(4, '1, 5'd0, '0, "R1");
        repeat (2) @(negedge clk_i);
        mon_en = 1'b0;
        rst_ni = 1'b0;
        #2 check("R1", result_o, 64'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule